// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block answers a cache miss by fetching a four-word line of 32-bit words from an internal memory and handing the words back one at a time over a one-word return path. It reproduces, cycle for cycle, the timing of one of four memory organisations, chosen at build time by a parameter:

- a narrow memory that is one word wide;
- the same narrow memory with open-row (page) access;
- a memory that is two words wide;
- four interleaved banks.

The cache controller raises a miss request with the line index while the block is idle. The block then shows `busy`. It returns each word with its index and a valid flag, pulses `line_done` with the final word, and afterwards reports the total refill latency. The storage is a set of four synchronous word banks, where bank i holds word i of every line. Each bank is seeded at reset with a computed pattern, so the contents are known.

Cycle numbering used below: the rising edge that accepts a request ends cycle 0. Cycle 1 is the one that follows, and it is the address cycle. Every output listed for cycle c is stable during that cycle.

Top module: `line_refill_seq`

## Requirements
- R1: After reset `busy`, `word_valid` and `line_done` are 0 and `last_latency` is 0.
- R2: A request is taken only at an edge where `busy` is 0. `busy` is 1 from cycle 1 through the last-word cycle T and is 0 in cycle T+1. Requests raised while busy are ignored, and the line being fetched is unaffected by them.
- R3: Words come out once each, in ascending index order (0, 1, 2, 3). Word i of line L carries the value ((4·L + i) + 1) × 32'h9E3779B9, truncated to 32 bits.
- R4: With the narrow organisation (ORG = 0), words appear in cycles 27, 52, 77 and 102, so T = 102.
- R5: With page access (ORG = 1), words appear in cycles 27, 35, 43 and 51, so T = 51.
- R6: With the two-word-wide organisation (ORG = 2), words appear in cycles 26, 27, 51 and 52, so T = 52.
- R7: With interleaved banks (ORG = 3), words appear in cycles 27, 28, 29 and 30, so T = 30.
- R8: `line_done` is 1 for exactly one cycle: the cycle in which word 3 is valid.
- R9: From cycle T+1 until the next refill ends, `last_latency` holds T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_req | input | 1 | Miss request, taken when idle |
| miss_line | input | LINE_AW | Index of the line to fetch |
| busy | output | 1 | Refill in progress |
| word_valid | output | 1 | A returned word is on `word_data` |
| word_idx | output | 2 | Position of the returned word in the line |
| word_data | output | DATA_W | Returned word |
| line_done | output | 1 | Last word of the line this cycle |
| last_latency | output | LAT_W | Cycle count of the latest finished refill |

## Verification
The assertions assume three things:

- `miss_line` is stable while the controller raises a request.
- The parameters give schedules whose totals fit in `last_latency`.
- The request sequence never relies on being accepted while `busy` is high.

The bench builds one instance per organisation and drives all four with the same stimulus. It sweeps every line index. During each refill it deliberately pulses a request with a different line, so that the ignore rule is exercised rather than assumed. It waits for all four instances to return to idle before it issues the next miss.

// File: rtl/refill_pkg.sv
// Shared types and schedule arithmetic for the line refill sequencer.
// Assumes a line of NWORD = 4 words; the organisation formulas rely on it.
package refill_pkg;

    localparam int NWORD = 4;

    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_PAGED  = 2'd1,
        ORG_DOUBLE = 2'd2,
        ORG_BANKED = 2'd3
    } org_e;

    // Cycle (counted from the address cycle = 1) in which word i is returned.
    function automatic int word_slot(org_e org, int t_acc, int t_page, int i);
        case (org)
            ORG_NARROW: return 2 + t_acc * (i + 1);
            ORG_PAGED:  return 2 + t_acc + t_page * i;
            ORG_DOUBLE: return 1 + t_acc * (i / 2 + 1) + (i % 2);
            default:    return 2 + t_acc + i;
        endcase
    endfunction

    // Number of words fetched by one memory access.
    function automatic int group_size(org_e org);
        case (org)
            ORG_DOUBLE: return 2;
            ORG_BANKED: return NWORD;
            default:    return 1;
        endcase
    endfunction

    // Reset seed of a word at word address a.
    function automatic logic [31:0] seed_word(int a, logic [31:0] seed);
        return 32'(a + 1) * seed;
    endfunction

endpackage

// File: rtl/refill_sched.sv
// Refill schedule counter.
// Counts cycles from acceptance and raises fire[i] one cycle before word i
// is due at the outputs. Assumes start is only raised while busy is low.
module refill_sched
    import refill_pkg::*;
#(
    parameter org_e ORG    = ORG_NARROW,
    parameter int   T_ACC  = 25,
    parameter int   T_PAGE = 8,
    parameter int   LAT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [NWORD-1:0] fire,
    output logic [LAT_W-1:0] last_latency
);

    localparam int TOTAL = word_slot(ORG, T_ACC, T_PAGE, NWORD - 1);

    logic [LAT_W-1:0] cnt;

    // Track busy span, advance the cycle count, capture latency at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            cnt          <= '0;
            last_latency <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LAT_W'(1);
        end else if (busy) begin
            if (cnt == LAT_W'(TOTAL)) begin
                busy         <= 1'b0;
                last_latency <= cnt;
                cnt          <= '0;
            end else begin
                cnt <= cnt + LAT_W'(1);
            end
        end
    end

    // One comparator per word against its scheduled slot.
    for (genvar i = 0; i < NWORD; i++) begin : g_slot
        localparam int SLOT = word_slot(ORG, T_ACC, T_PAGE, i);
        assign fire[i] = busy && (cnt == LAT_W'(SLOT - 1));
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> last_latency == LAT_W'(TOTAL));

    // R2
    span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cnt == LAT_W'(1));

endmodule

// File: rtl/refill_bank.sv
// One synchronous word bank. It holds word BANK_ID of every line and is
// seeded from a computed pattern during reset. Its read data is registered
// and held until the next read.
module refill_bank
    import refill_pkg::*;
#(
    parameter int          LINES   = 16,
    parameter int          DATA_W  = 32,
    parameter int          BANK_ID = 0,
    parameter logic [31:0] SEED    = 32'h9E3779B9,
    localparam int         LINE_AW = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [LINE_AW-1:0] rd_line,
    output logic [DATA_W-1:0]  rd_data
);

    logic [DATA_W-1:0] mem [LINES];

    // Seed the array at reset; otherwise perform registered reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                mem[l] <= DATA_W'(seed_word(l * NWORD + BANK_ID, SEED));
            end
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_line];
        end
    end

endmodule

// File: rtl/refill_return.sv
// Word return stage.
// Turns the one-cycle-early fire vector into registered valid, index and
// done flags, and selects the matching bank's held data. Assumes at most
// one fire bit is set in any cycle.
module refill_return
    import refill_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NWORD-1:0]             fire,
    input  logic [NWORD-1:0][DATA_W-1:0] bank_q,
    output logic                         word_valid,
    output logic [1:0]                   word_idx,
    output logic [DATA_W-1:0]            word_data,
    output logic                         line_done
);

    logic [1:0] enc;

    // Encode the fire vector into a word index.
    always_comb begin
        enc = '0;
        for (int i = 0; i < NWORD; i++) begin
            if (fire[i]) enc = 2'(i);
        end
    end

    // Register the return flags so they line up with the bank read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_idx   <= '0;
            line_done  <= 1'b0;
        end else begin
            word_valid <= |fire;
            line_done  <= fire[NWORD-1];
            if (|fire) word_idx <= enc;
        end
    end

    // Present the word held by the bank named by the index.
    assign word_data = bank_q[word_idx];

    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (word_valid && word_idx == 2'd3));

    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> (!word_valid || word_idx == $past(word_idx) + 2'd1));

    // R3
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire));

endmodule

// File: rtl/line_refill_seq.sv
// Cache line refill sequencer (top).
// Takes a miss when idle, latches the line index, and fetches the line from
// four word banks. The grouping of bank reads follows ORG; the return
// timing follows the schedule of ORG. Assumes miss_line is valid with
// miss_req.
module line_refill_seq
    import refill_pkg::*;
#(
    parameter org_e        ORG     = ORG_NARROW,
    parameter int          LINES   = 16,
    parameter int          DATA_W  = 32,
    parameter int          T_ACC   = 25,
    parameter int          T_PAGE  = 8,
    parameter int          LAT_W   = 8,
    parameter logic [31:0] SEED    = 32'h9E3779B9,
    localparam int         LINE_AW = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_req,
    input  logic [LINE_AW-1:0] miss_line,
    output logic               busy,
    output logic               word_valid,
    output logic [1:0]         word_idx,
    output logic [DATA_W-1:0]  word_data,
    output logic               line_done,
    output logic [LAT_W-1:0]   last_latency
);

    localparam int GRP = group_size(ORG);

    logic                         accept;
    logic [LINE_AW-1:0]           line_q;
    logic [NWORD-1:0]             fire;
    logic [NWORD-1:0]             rd_en;
    logic [NWORD-1:0][DATA_W-1:0] bank_q;

    assign accept = miss_req && !busy;

    // Latch the line index of an accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else if (accept) line_q <= miss_line;
    end

    refill_sched #(
        .ORG   (ORG),
        .T_ACC (T_ACC),
        .T_PAGE(T_PAGE),
        .LAT_W (LAT_W)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .busy        (busy),
        .fire        (fire),
        .last_latency(last_latency)
    );

    // One bank per word; banks of one access group read together at the
    // slot of the group's first word.
    for (genvar b = 0; b < NWORD; b++) begin : g_bank
        assign rd_en[b] = fire[b - (b % GRP)];
        refill_bank #(
            .LINES  (LINES),
            .DATA_W (DATA_W),
            .BANK_ID(b),
            .SEED   (SEED)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (rd_en[b]),
            .rd_line(line_q),
            .rd_data(bank_q[b])
        );
    end

    refill_return #(
        .DATA_W(DATA_W)
    ) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .bank_q    (bank_q),
        .word_valid(word_valid),
        .word_idx  (word_idx),
        .word_data (word_data),
        .line_done (line_done)
    );

    // R2
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> busy);

    // R2
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(line_q));

endmodule

// File: tb/tb_line_refill_seq.sv
// Bench: one instance per organisation, all driven alike; sweeps every line.
module tb_line_refill_seq;
    import refill_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req;
    logic [3:0] line;

    logic [3:0]  busy_v, val_v, done_v;
    logic [1:0]  idx_v [4];
    logic [31:0] dat_v [4];
    logic [7:0]  lat_v [4];

    int n_run  = 0;
    int n_fail = 0;

    string org_req [4] = '{"R4", "R5", "R6", "R7"};

    always #5 clk = ~clk;

    for (genvar m = 0; m < 4; m++) begin : g_org
        line_refill_seq #(.ORG(org_e'(m))) dut (
            .clk         (clk),
            .rst_n       (rst_n),
            .miss_req    (req),
            .miss_line   (line),
            .busy        (busy_v[m]),
            .word_valid  (val_v[m]),
            .word_idx    (idx_v[m]),
            .word_data   (dat_v[m]),
            .line_done   (done_v[m]),
            .last_latency(lat_v[m])
        );
    end

    function automatic int exp_slot(int m, int i);
        case (m)
            0:       return 27 + 25 * i;
            1:       return 27 + 8 * i;
            2:       return (i < 2) ? 26 + i : 49 + i;
            default: return 27 + i;
        endcase
    endfunction

    function automatic logic [31:0] pat(int a);
        return 32'(a + 1) * 32'h9E3779B9;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic check_cycle(int ln, int c);
        for (int m = 0; m < 4; m++) begin
            int  t  = exp_slot(m, 3);
            bit  ev = 1'b0;
            int  ei = 0;
            for (int i = 0; i < 4; i++) begin
                if (exp_slot(m, i) == c) begin
                    ev = 1'b1;
                    ei = i;
                end
            end
            chk(busy_v[m] == (c <= t), "R2", "busy", busy_v[m], c <= t);
            chk(val_v[m] == ev, org_req[m], "word_valid", val_v[m], ev);
            chk(done_v[m] == (c == t), "R8", "line_done", done_v[m], c == t);
            if (ev) begin
                chk(idx_v[m] == 2'(ei), "R3", "word_idx", idx_v[m], ei);
                chk(dat_v[m] == pat(ln * 4 + ei), "R3", "word_data",
                    dat_v[m], pat(ln * 4 + ei));
            end
            if (c == t + 1) begin
                chk(lat_v[m] == 8'(t), "R9", "last_latency", lat_v[m], t);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        req   = 1'b0;
        line  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int m = 0; m < 4; m++) begin
            chk(busy_v[m] == 1'b0, "R1", "busy", busy_v[m], 0);
            chk(val_v[m] == 1'b0, "R1", "word_valid", val_v[m], 0);
            chk(done_v[m] == 1'b0, "R1", "line_done", done_v[m], 0);
            chk(lat_v[m] == 8'd0, "R1", "last_latency", lat_v[m], 0);
        end
        for (int ln = 0; ln < 16; ln++) begin
            line = 4'(ln);
            req  = 1'b1;
            @(negedge clk);
            for (int c = 1; c <= 106; c++) begin
                check_cycle(ln, c);
                // R2 requests while busy, with another line, must be ignored
                req  = (c == 3 || c == 4);
                line = (c == 3 || c == 4) ? 4'(~ln) : 4'(ln);
                @(negedge clk);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule